// File: doc/BRIEF.md
# Programmable ROM Pin-Mode Decoder with Identifier Readout

This block is a synthesizable behavioural model of the control and output side of a byte-wide, electrically erasable programmable ROM. Each clock it reads the abstract level of the chip-enable pin, the shared output-enable/programming-supply pin and address line 9. Each level is low, logic high or high voltage. From these levels it selects one operating mode. The mode controls three things: whether the byte bus is driven, whether the stored array is read, cleared bit by bit, or restored to all ones, and whether a fixed identifier byte is returned in place of the array contents.

The array is held in registers inside the block and is addressed by the full address bus. High-impedance is modelled by a drive-enable output, and the data value is forced to zero whenever that enable is low. A small mode code is brought out so that a host or a bench can observe the decode directly. An error flag reports an identify request in which any address line other than bits 0 and 9 is high.

Top module: `eprom_ctl`

## Requirements
- R1: Pin level codes are 2'b00 low, 2'b01 logic high, and 2'b10 or 2'b11 high voltage. When chip enable is not low, the mode is standby (code 0), or program-inhibit (code 4) if the output-enable/supply pin is at high voltage. In both cases `data_oe` is 0.
- R2: When chip enable is low, the output-enable/supply pin is low and `a9_hv` is 0, the mode is read (code 1). `data_oe` is 1 and `data_out` equals the byte stored at `addr`. This also serves as program verify and erase verify.
- R3: When chip enable is low and the output-enable/supply pin is at logic high, the mode is output disable (code 2), `data_oe` is 0 and `data_out` is 0.
- R4: When chip enable is low, the output-enable/supply pin is at high voltage and `a9_hv` is 0, the mode is program (code 3) and `data_oe` is 0. At each clock edge the byte at `addr` becomes its old value AND `data_in`.
- R5: Programming never turns a 0 bit back into 1. Programming with 8'hFF leaves the byte unchanged.
- R6: When chip enable is low, the output-enable/supply pin is at high voltage and `a9_hv` is 1, the mode is erase (code 5) and `data_oe` is 0. After the clock edge every byte of the array reads 8'hFF.
- R7: In program-inhibit no byte of the array changes, whatever `data_in` and `addr` are.
- R8: When chip enable is low, the output-enable/supply pin is low, `a9_hv` is 1 and `addr[8:1]` is zero, the mode is identify (code 6) and `data_oe` is 1. `data_out` is 8'hC2 when `addr[0]` is 0 and 8'hD1 when `addr[0]` is 1. `addr[9]` is ignored in this mode.
- R9: When the identify conditions hold but `addr[8:1]` is nonzero, the mode is identify-error (code 7), `id_err` is 1 and `data_oe` is 0. In every other mode `id_err` is 0.
- R10: After reset every byte of the array reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; fills the array with ones |
| ce_lvl | input | 2 | Chip-enable pin level code |
| oe_lvl | input | 2 | Output-enable / programming-supply pin level code |
| a9_hv | input | 1 | Address line 9 held at high voltage |
| addr | input | ADDR_W (10) | Address bus at logic levels |
| data_in | input | 8 | Byte presented on the bus while programming |
| data_out | output | 8 | Byte driven on the bus, zero when not driven |
| data_oe | output | 1 | Bus drive enable; 0 models high impedance |
| mode | output | 3 | Decoded mode code |
| id_err | output | 1 | Identify request with stray address bits high |

## Verification
The hardest case to reach is the clear-only write history of a single byte. That byte has to be hit by several program pulses with different data and then read back before an erase restores it. Random addresses spread over 1024 locations rarely give that sequence. The bench therefore folds most random addresses into sixteen locations and keeps the erase combination rare, so that bytes build up several partial clears between erases. Directed steps cover the identify bytes, a logic-high A9 during identify, stray address bits, and program-inhibit followed by read-back.

// File: rtl/eprom_ctl_pkg.sv
package eprom_ctl_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY = 3'd0,
    MD_READ    = 3'd1,
    MD_OUT_DIS = 3'd2,
    MD_PROGRAM = 3'd3,
    MD_INHIBIT = 3'd4,
    MD_ERASE   = 3'd5,
    MD_IDENT   = 3'd6,
    MD_ID_ERR  = 3'd7
  } mode_e;

  function automatic logic lvl_low(input logic [1:0] lvl);
    return lvl == 2'b00;
  endfunction

  function automatic logic lvl_hv(input logic [1:0] lvl);
    return lvl[1];
  endfunction

  // Priority: chip select first, then supply voltage, then output gate.
  function automatic mode_e pick_mode(input logic [1:0] ce, input logic [1:0] oe,
                                      input logic a9_hv, input logic stray);
    if (!lvl_low(ce))  return lvl_hv(oe) ? MD_INHIBIT : MD_STANDBY;
    if (lvl_hv(oe))    return a9_hv ? MD_ERASE : MD_PROGRAM;
    if (!lvl_low(oe))  return MD_OUT_DIS;
    if (a9_hv)         return stray ? MD_ID_ERR : MD_IDENT;
    return MD_READ;
  endfunction

endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
  import eprom_ctl_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int SEL_BIT = 0,
  parameter int HV_BIT  = 9
) (
  input  logic [1:0]        ce_lvl,
  input  logic [1:0]        oe_lvl,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  output mode_e             mode,
  output logic              drive_array,
  output logic              drive_id,
  output logic              wr_fire,
  output logic              erase_fire,
  output logic              id_err
);
  localparam logic [ADDR_W-1:0] ID_MASK =
    ~((ADDR_W'(1) << SEL_BIT) | (ADDR_W'(1) << HV_BIT));

  logic stray;
  assign stray = |(addr & ID_MASK);

  always_comb begin
    mode        = pick_mode(ce_lvl, oe_lvl, a9_hv, stray);
    drive_array = (mode == MD_READ);
    drive_id    = (mode == MD_IDENT);
    wr_fire     = (mode == MD_PROGRAM);
    erase_fire  = (mode == MD_ERASE);
    id_err      = (mode == MD_ID_ERR);
  end
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || erase) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_en) begin
      cells[addr] <= cells[addr] & wdata;
    end
  end

  assign rdata = cells[addr];

  // R4: a program pulse clears only the bits that are low in the pulse data
  a_r4_clear_only: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && !$past(erase) && $stable(addr))
      |-> rdata == ($past(rdata) & $past(wdata)));

  // R6: erase restores ones
  a_r6_erase_ones: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(erase)) |-> rdata == '1);

  // R10: fresh array reads all ones
  a_r10_reset_ones: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rdata == '1);

  // R5: without a write or erase, the byte under a steady address holds
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && !$past(erase) && $stable(addr))
      |-> $stable(rdata));
endmodule

// File: rtl/eprom_id_rom.sv
module eprom_id_rom #(
  parameter logic [7:0] MFR_CODE = 8'hC2,
  parameter logic [7:0] DEV_CODE = 8'hD1
) (
  input  logic       sel,
  output logic [7:0] code
);
  assign code = sel ? DEV_CODE : MFR_CODE;
endmodule

// File: rtl/eprom_ctl.sv
module eprom_ctl
  import eprom_ctl_pkg::*;
#(
  parameter int         ADDR_W   = 10,
  parameter logic [7:0] MFR_CODE = 8'hC2,
  parameter logic [7:0] DEV_CODE = 8'hD1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        ce_lvl,
  input  logic [1:0]        oe_lvl,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data_in,
  output logic [7:0]        data_out,
  output logic              data_oe,
  output logic [2:0]        mode,
  output logic              id_err
);
  localparam int SEL_BIT = 0;
  localparam int HV_BIT  = 9;

  mode_e      mode_q;
  logic       drive_array, drive_id, wr_fire, erase_fire;
  logic [7:0] array_byte, id_byte;

  eprom_mode_decode #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT), .HV_BIT(HV_BIT)) u_dec (
    .ce_lvl(ce_lvl), .oe_lvl(oe_lvl), .a9_hv(a9_hv), .addr(addr),
    .mode(mode_q), .drive_array(drive_array), .drive_id(drive_id),
    .wr_fire(wr_fire), .erase_fire(erase_fire), .id_err(id_err)
  );

  eprom_cell_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_arr (
    .clk(clk), .rst(rst), .wr_en(wr_fire), .erase(erase_fire),
    .addr(addr), .wdata(data_in), .rdata(array_byte)
  );

  eprom_id_rom #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .sel(addr[SEL_BIT]), .code(id_byte)
  );

  always_comb begin
    data_oe  = drive_array | drive_id;
    data_out = drive_id ? id_byte : (drive_array ? array_byte : 8'h00);
    mode     = mode_q;
  end

  // R1: a deselected chip never drives the bus
  a_r1_deselect_hiz: assert property (@(posedge clk) disable iff (rst)
    !lvl_low(ce_lvl) |-> !data_oe);

  // R9: an identify error keeps the bus released
  a_r9_err_quiet: assert property (@(posedge clk) disable iff (rst)
    id_err |-> (!data_oe && data_out == 8'h00));

  // R8: identify returns the code chosen by address bit 0
  a_r8_id_code: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_IDENT) |-> data_out == (addr[SEL_BIT] ? DEV_CODE : MFR_CODE));

  // R4: the bus is an input while the supply pin is at high voltage
  a_r4_bus_input: assert property (@(posedge clk) disable iff (rst)
    lvl_hv(oe_lvl) |-> !data_oe);
endmodule

// File: tb/eprom_ctl_bench.sv
`timescale 1ns/1ps
module eprom_ctl_bench;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    ce_lvl = 2'b01, oe_lvl = 2'b01;
  logic          a9_hv = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    data_in = 8'h00;
  logic [7:0]    data_out;
  logic          data_oe, id_err;
  logic [2:0]    mode;

  int tests = 0, fails = 0;
  logic [7:0] model [DEPTH];

  always #4 clk = ~clk;

  eprom_ctl u_eprom_ctl (
    .clk(clk), .rst(rst), .ce_lvl(ce_lvl), .oe_lvl(oe_lvl), .a9_hv(a9_hv),
    .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .mode(mode), .id_err(id_err)
  );

  function automatic logic [2:0] want_mode(input logic [1:0] c, input logic [1:0] o,
                                           input logic h, input logic [AW-1:0] a);
    case ({c != 2'b00, o[1], o == 2'b01, h})
      4'b1000, 4'b1010, 4'b1001, 4'b1011: return 3'd0;
      4'b1100, 4'b1101:                   return 3'd4;
      4'b0100:                            return 3'd3;
      4'b0101:                            return 3'd5;
      4'b0010, 4'b0011:                   return 3'd2;
      4'b0001:                            return (a[8:1] == 8'd0) ? 3'd6 : 3'd7;
      default:                            return 3'd1;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd0, 3'd4: return "R1";
      3'd1:       return "R2";
      3'd2:       return "R3";
      3'd3:       return "R4";
      3'd5:       return "R6";
      3'd6:       return "R8";
      default:    return "R9";
    endcase
  endfunction

  task automatic check_now(input string tag);
    logic [2:0] m;
    logic       eo, ee;
    logic [7:0] ed;
    m  = want_mode(ce_lvl, oe_lvl, a9_hv, addr);
    eo = (m == 3'd1) || (m == 3'd6);
    ee = (m == 3'd7);
    ed = (m == 3'd1) ? model[addr] : (m == 3'd6) ? (addr[0] ? 8'hD1 : 8'hC2) : 8'h00;
    tests++;
    if (mode !== m || data_oe !== eo || data_out !== ed || id_err !== ee) begin
      fails++;
      $display("FAIL %s: mode=%0d oe=%b data=%h err=%b expected mode=%0d oe=%b data=%h err=%b",
               tag, mode, data_oe, data_out, id_err, m, eo, ed, ee);
    end
  endtask

  task automatic step(input logic [1:0] c, input logic [1:0] o, input logic h,
                      input logic [AW-1:0] a, input logic [7:0] d, input string tag);
    logic [2:0] m;
    @(negedge clk);
    ce_lvl = c; oe_lvl = o; a9_hv = h; addr = a; data_in = d;
    #1;
    check_now(tag == "" ? tag_of(want_mode(c, o, h, a)) : tag);
    m = want_mode(c, o, h, a);
    @(posedge clk);
    if (m == 3'd5) for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    else if (m == 3'd3) model[a] = model[a] & d;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    step(2'b00, 2'b00, 1'b0, 10'h005, 8'h00, "R10");
    step(2'b00, 2'b00, 1'b0, 10'h3FF, 8'h00, "R10");
    step(2'b01, 2'b00, 1'b0, 10'h005, 8'h00, "R1");
    step(2'b10, 2'b01, 1'b0, 10'h005, 8'h00, "R1");
    step(2'b00, 2'b10, 1'b0, 10'h003, 8'hA5, "R4");
    step(2'b00, 2'b00, 1'b0, 10'h003, 8'h00, "R4");
    step(2'b00, 2'b11, 1'b0, 10'h003, 8'h0F, "R4");
    step(2'b00, 2'b00, 1'b0, 10'h003, 8'h00, "R4");
    step(2'b00, 2'b10, 1'b0, 10'h003, 8'hFF, "R5");
    step(2'b00, 2'b00, 1'b0, 10'h003, 8'h00, "R5");
    step(2'b01, 2'b10, 1'b0, 10'h003, 8'h00, "R7");
    step(2'b11, 2'b11, 1'b1, 10'h003, 8'h00, "R7");
    step(2'b00, 2'b00, 1'b0, 10'h003, 8'h00, "R7");
    step(2'b00, 2'b01, 1'b0, 10'h003, 8'h00, "R3");
    step(2'b00, 2'b01, 1'b1, 10'h000, 8'h00, "R3");
    step(2'b00, 2'b00, 1'b1, 10'h000, 8'h00, "R8");
    step(2'b00, 2'b00, 1'b1, 10'h001, 8'h00, "R8");
    step(2'b00, 2'b00, 1'b1, 10'h201, 8'h00, "R8");
    step(2'b00, 2'b00, 1'b1, 10'h004, 8'h00, "R9");
    step(2'b00, 2'b00, 1'b1, 10'h100, 8'h00, "R9");
    step(2'b00, 2'b10, 1'b1, 10'h000, 8'h00, "R6");
    step(2'b00, 2'b00, 1'b0, 10'h003, 8'h00, "R6");

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      logic [AW-1:0] a;
      r = $urandom;
      case (r[13:12])
        2'd0:    a = r[9:0];
        2'd1:    a = {r[9], 8'd0, r[0]};
        default: a = {6'd0, r[3:0]};
      endcase
      step(r[15:14], r[17:16], r[20:18] == 3'd0, a, r[31:24], "");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule